// File: doc/BRIEF.md
# I2C Target Read-Direction Transmit Engine

This block sends bytes from an I2C target to the bus controller once a read transfer has been addressed to it. It holds one byte that software has written in a holding buffer and a byte counter that software loads with the transfer length. When a byte is due, the buffer moves into a shift register, which puts the byte on SDA one bit at a time, most significant bit first. The block also acknowledges the address, samples the controller's acknowledge after each byte, and keeps the status flags that software polls or takes interrupts from.

A bus-level front end supplies single-cycle strobes for the SCL rising and falling edges, the SCL and SDA levels, stop and repeated-start detection, and a strobe when a read address has matched. The block returns the level to drive on SDA, where 1 means released. It also returns a hold request that keeps SCL low. The block holds SCL when the buffer is empty while bytes remain to be sent. It also holds SCL at acknowledge time when that hold is enabled. Software releases the first kind of hold by writing the buffer and the second by clearing the stretch bit. A stretch-disable input removes the hold from the bus, but the stretch status bit is still kept up to date.

Top module: `i2c_stx_engine`

## Requirements
- R1: After reset, SDA is released (sda_out=1), scl_hold=0, stretch=0, active=0, tx_empty=1, tx_irq=1, count=0, ack_stat=0 and every status flag is 0.
- R2: On an address-match strobe without a pending receive overflow, active is set and SDA is driven low (acknowledge). If the buffer is empty, the transmit flag is set and the count is non-zero, the stretch bit is also set. With a zero count it stays clear.
- R3: A buffer write clears tx_empty and tx_irq. It also clears a stretch caused by an empty buffer. It does not clear a stretch caused by the acknowledge-time hold, which only stretch_clr removes.
- R4: On the SCL falling edge that ends an acknowledged acknowledge bit, a non-zero count moves the buffered byte into the shift register, sets tx_empty and tx_irq, and decrements the count by one. If the count becomes 0, flags[1] (count flag) is set. If the count is already 0, nothing is loaded and SDA is released.
- R5: The loaded byte appears on sda_out most significant bit first. The output advances one bit on each SCL falling edge. SDA is released whenever no data bit or acknowledge is being driven.
- R6: On the SCL falling edge that ends the eighth data bit, if the buffer is empty and the count is non-zero, the stretch bit is set.
- R7: On the SCL rising edge of the acknowledge bit, sda_in is copied to ack_stat and flags[0] (acknowledge-time flag) is set. When ackt_hold_en is 1, the stretch bit is also set and irq goes high. The same flag and hold apply after the target's own address acknowledge.
- R8: An address match while rx_ovf is 1 gives a not-acknowledge: SDA stays released, flags[2] (NACK flag) is set, active is 0 and the stretch bit is not changed.
- R9: A not-acknowledge from the controller sets flags[2] and clears active. err_irq equals flags[2] AND nack_ie, so it clears only when that flag is cleared.
- R10: A stop strobe sets flags[3] and a repeated-start strobe sets flags[4]. Either one returns the block to idle with active cleared.
- R11: scl_hold is 1 only while the stretch bit is 1, stretch_dis is 0 and SCL is low. With stretch_dis=1 the stretch bit and flags still update.
- R12: Writing 1 to a bit of flag_clr clears the matching flag. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Synchronised SCL level |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| sda_in | input | 1 | Synchronised SDA level |
| stop_det | input | 1 | Stop condition strobe |
| restart_det | input | 1 | Repeated-start strobe |
| addr_rd_match | input | 1 | Read address matched, given after the eighth address falling edge |
| rx_ovf | input | 1 | Receive overflow pending |
| stretch_dis | input | 1 | Suppress all SCL holds |
| ackt_hold_en | input | 1 | Hold SCL and raise irq at acknowledge time |
| nack_ie | input | 1 | Enable err_irq from the NACK flag |
| tx_wr | input | 1 | Write strobe for the holding buffer |
| tx_wdata | input | 8 | Byte to transmit |
| stretch_clr | input | 1 | Clear the stretch bit |
| cnt_ld | input | 1 | Load strobe for the byte counter |
| cnt_wdata | input | CNT_W | Byte count to load |
| flag_clr | input | 5 | Write-1-to-clear for flags |
| sda_out | output | 1 | SDA level to drive, 1 = released |
| scl_hold | output | 1 | Hold SCL low |
| stretch | output | 1 | Stretch status bit |
| ack_stat | output | 1 | Last acknowledge from the controller, 1 = NACK |
| active | output | 1 | Target transfer active |
| tx_empty | output | 1 | Holding buffer empty |
| tx_irq | output | 1 | Transmit flag |
| cnt | output | CNT_W | Remaining byte count |
| flags | output | 5 | [0] ack time, [1] count, [2] NACK, [3] stop, [4] restart |
| irq | output | 1 | Acknowledge-time interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
Every status bit, the count and the flags are registers. They take their new value at the first clock edge that samples a strobe and can be read on the next falling clock edge. sda_out is decoded from registered state and registered shift data, so it follows the same one-edge delay. scl_hold is a combination of the registered stretch bit with the live scl_in and stretch_dis levels, so it changes as soon as those inputs change. The bench drives each strobe on a falling clock edge and holds it for exactly one cycle. It checks the results at the next falling edge, and it checks scl_hold one nanosecond after a level change.

// File: rtl/i2c_stx_pkg.sv
`timescale 1ns/1ps
package i2c_stx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACKOUT = 2'd1,
      ST_SHIFT  = 2'd2,
      ST_ACKIN  = 2'd3
   } stx_state_e;

   localparam int FL_ACKT   = 0;
   localparam int FL_CNT    = 1;
   localparam int FL_NACK   = 2;
   localparam int FL_STOP   = 3;
   localparam int FL_RSTRT  = 4;
   localparam int NUM_FLAGS = 5;
endpackage

// File: rtl/i2c_stx_holdbuf.sv
`timescale 1ns/1ps
module i2c_stx_holdbuf #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              take,
   output logic [BYTE_W-1:0] data,
   output logic              empty,
   output logic              txif
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         empty <= 1'b1;
         txif  <= 1'b1;
      end else begin
         if (take) begin
            empty <= 1'b1;
            txif  <= 1'b1;
         end
         if (wr) begin
            data  <= wdata;
            empty <= 1'b0;
            txif  <= 1'b0;
         end
      end
   end

   // R3: a write always leaves the buffer full with the transmit flag clear
   a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (!empty && !txif));
endmodule

// File: rtl/i2c_stx_shifter.sv
`timescale 1ns/1ps
module i2c_stx_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] ld_data,
   input  logic              shift,
   output logic              msb,
   output logic              at_last
);
   localparam int BIT_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh_q;
   logic [BIT_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= ld_data;
         idx_q <= '0;
      end else if (shift) begin
         sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign msb     = sh_q[BYTE_W-1];
   assign at_last = (idx_q == BIT_W'(BYTE_W-1));

   // R5: the bit on the wire only moves on a shift or a load
   a_r5_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(sh_q));
endmodule

// File: rtl/i2c_stx_bytecnt.sv
`timescale 1ns/1ps
module i2c_stx_bytecnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             nonzero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (ld)                cnt <= ld_val;
      else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign nonzero = (cnt != '0);

   // R4: each transferred byte takes exactly one count
   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !ld && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/i2c_stx_engine.sv
`timescale 1ns/1ps
module i2c_stx_engine
   import i2c_stx_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_in,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 sda_in,
   input  logic                 stop_det,
   input  logic                 restart_det,
   input  logic                 addr_rd_match,
   input  logic                 rx_ovf,
   input  logic                 stretch_dis,
   input  logic                 ackt_hold_en,
   input  logic                 nack_ie,
   input  logic                 tx_wr,
   input  logic [BYTE_W-1:0]    tx_wdata,
   input  logic                 stretch_clr,
   input  logic                 cnt_ld,
   input  logic [CNT_W-1:0]     cnt_wdata,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   output logic                 sda_out,
   output logic                 scl_hold,
   output logic                 stretch,
   output logic                 ack_stat,
   output logic                 active,
   output logic                 tx_empty,
   output logic                 tx_irq,
   output logic [CNT_W-1:0]     cnt,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 irq,
   output logic                 err_irq
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("i2c_stx_engine: BYTE_W must be 8 for an I2C byte");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("i2c_stx_engine: CNT_W must be at least 1");
   end

   stx_state_e           st_q, st_d;
   logic                 active_d, ack_stat_d;
   logic                 take, dec, shift_en;
   logic                 set_st_empty, set_st_ack;
   logic                 hold_ack_q;
   logic [NUM_FLAGS-1:0] set_flag;
   logic [BYTE_W-1:0]    buf_data;
   logic                 cnt_nz, sh_msb, sh_last;

   i2c_stx_holdbuf #(.BYTE_W(BYTE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata), .take(take),
      .data(buf_data), .empty(tx_empty), .txif(tx_irq)
   );

   i2c_stx_shifter #(.BYTE_W(BYTE_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(take), .ld_data(buf_data),
      .shift(shift_en), .msb(sh_msb), .at_last(sh_last)
   );

   i2c_stx_bytecnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(cnt_wdata), .dec(dec),
      .cnt(cnt), .nonzero(cnt_nz)
   );

   // transfer sequencing
   always_comb begin
      st_d         = st_q;
      active_d     = active;
      ack_stat_d   = ack_stat;
      take         = 1'b0;
      dec          = 1'b0;
      shift_en     = 1'b0;
      set_st_empty = 1'b0;
      set_st_ack   = 1'b0;
      set_flag     = '0;
      if (stop_det || restart_det) begin
         st_d               = ST_IDLE;
         active_d           = 1'b0;
         set_flag[FL_STOP]  = stop_det;
         set_flag[FL_RSTRT] = restart_det;
      end else if (addr_rd_match) begin
         if (rx_ovf) begin
            st_d              = ST_IDLE;
            active_d          = 1'b0;
            set_flag[FL_NACK] = 1'b1;
         end else begin
            st_d     = ST_ACKOUT;
            active_d = 1'b1;
            if (tx_empty && cnt_nz && tx_irq) set_st_empty = 1'b1;
         end
      end else begin
         unique case (st_q)
            ST_ACKOUT: if (scl_fall) begin
               set_flag[FL_ACKT] = 1'b1;
               set_st_ack        = ackt_hold_en;
               if (cnt_nz) begin
                  take = 1'b1;
                  dec  = 1'b1;
                  st_d = ST_SHIFT;
               end else begin
                  st_d = ST_IDLE;
               end
            end
            ST_SHIFT: if (scl_fall) begin
               shift_en = 1'b1;
               if (sh_last) begin
                  st_d = ST_ACKIN;
                  if (tx_empty && cnt_nz) set_st_empty = 1'b1;
               end
            end
            ST_ACKIN: if (scl_rise) begin
               ack_stat_d        = sda_in;
               set_flag[FL_ACKT] = 1'b1;
               set_st_ack        = ackt_hold_en;
            end else if (scl_fall) begin
               if (!ack_stat) begin
                  if (cnt_nz) begin
                     take = 1'b1;
                     dec  = 1'b1;
                     st_d = ST_SHIFT;
                  end else begin
                     st_d = ST_IDLE;
                  end
               end else begin
                  set_flag[FL_NACK] = 1'b1;
                  active_d          = 1'b0;
                  st_d              = ST_IDLE;
               end
            end
            default: ;
         endcase
      end
      set_flag[FL_CNT] = dec && (cnt == CNT_ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         active   <= 1'b0;
         ack_stat <= 1'b0;
      end else begin
         st_q     <= st_d;
         active   <= active_d;
         ack_stat <= ack_stat_d;
      end
   end

   // stretch bit: empty-buffer holds end on a write, acknowledge holds on a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stretch    <= 1'b0;
         hold_ack_q <= 1'b0;
      end else if (set_st_ack) begin
         stretch    <= 1'b1;
         hold_ack_q <= 1'b1;
      end else if (set_st_empty) begin
         stretch    <= 1'b1;
      end else if (stretch_clr) begin
         stretch    <= 1'b0;
         hold_ack_q <= 1'b0;
      end else if (tx_wr && !hold_ack_q) begin
         stretch    <= 1'b0;
      end
   end

   // sticky status flags, set has priority over write-1-to-clear
   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= set_flag[g] | (bit_q & ~flag_clr[g]);
      end
      assign flags[g] = bit_q;
   end

   always_comb begin
      unique case (st_q)
         ST_ACKOUT: sda_out = 1'b0;
         ST_SHIFT:  sda_out = sh_msb;
         default:   sda_out = 1'b1;
      endcase
   end

   assign scl_hold = stretch & ~stretch_dis & ~scl_in;
   assign irq      = flags[FL_ACKT] & ackt_hold_en;
   assign err_irq  = flags[FL_NACK] & nack_ie;

   // R7: the controller's acknowledge is captured on the ninth rising edge
   a_r7_ack_sampled: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACKIN && scl_rise && !stop_det && !restart_det && !addr_rd_match)
      |=> (ack_stat == $past(sda_in)));

   // R9: a newly raised NACK flag always coincides with an inactive target
   a_r9_nack_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FL_NACK]) |-> !active);
endmodule

// File: tb/i2c_stx_engine_tb.sv
`timescale 1ns/1ps
module i2c_stx_engine_tb_top;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_in = 1'b1, scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
   logic stop_det = 1'b0, restart_det = 1'b0, addr_rd_match = 1'b0, rx_ovf = 1'b0;
   logic stretch_dis = 1'b0, ackt_hold_en = 1'b0, nack_ie = 1'b0;
   logic tx_wr = 1'b0, stretch_clr = 1'b0, cnt_ld = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic [4:0] flag_clr = '0;
   logic sda_out, scl_hold, stretch, ack_stat, active, tx_empty, tx_irq, irq, err_irq;
   logic [CNT_W-1:0] cnt;
   logic [4:0] flags;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   i2c_stx_engine #(.BYTE_W(8), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .sda_in(sda_in), .stop_det(stop_det),
      .restart_det(restart_det), .addr_rd_match(addr_rd_match), .rx_ovf(rx_ovf),
      .stretch_dis(stretch_dis), .ackt_hold_en(ackt_hold_en), .nack_ie(nack_ie),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .stretch_clr(stretch_clr),
      .cnt_ld(cnt_ld), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
      .sda_out(sda_out), .scl_hold(scl_hold), .stretch(stretch),
      .ack_stat(ack_stat), .active(active), .tx_empty(tx_empty), .tx_irq(tx_irq),
      .cnt(cnt), .flags(flags), .irq(irq), .err_irq(err_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {stretch_dis, ackt_hold_en, nack_ie, rx_ovf} = '0;
      scl_in = 1'b0;
      sda_in = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rise(input logic s);
      sda_in = s; scl_in = 1'b1; scl_rise = 1'b1;
      @(negedge clk); scl_rise = 1'b0;
   endtask

   task automatic fall();
      scl_in = 1'b0; scl_fall = 1'b1;
      @(negedge clk); scl_fall = 1'b0;
   endtask

   task automatic wr_tx(input logic [7:0] d);
      tx_wdata = d; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic ld_cnt(input int n);
      cnt_wdata = CNT_W'(n); cnt_ld = 1'b1;
      @(negedge clk); cnt_ld = 1'b0;
   endtask

   task automatic match();
      addr_rd_match = 1'b1;
      @(negedge clk); addr_rd_match = 1'b0;
   endtask

   task automatic pulse_clr(input logic [4:0] m);
      flag_clr = m;
      @(negedge clk); flag_clr = '0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         chk("R5 data bit", sda_out, b[i]);
         rise(1'b1);
         fall();
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 sda released", sda_out, 1);
      chk("R1 scl_hold", scl_hold, 0);
      chk("R1 stretch", stretch, 0);
      chk("R1 active", active, 0);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 tx_irq", tx_irq, 1);
      chk("R1 count", cnt, 0);
      chk("R1 ack_stat", ack_stat, 0);
      chk("R1 flags", flags, 0);
   endtask

   task automatic t_stream();
      do_reset();
      nack_ie = 1'b1;
      ld_cnt(2);
      match();
      chk("R2 active", active, 1);
      chk("R2 address ack driven", sda_out, 0);
      chk("R2 stretch on empty", stretch, 1);
      chk("R11 hold while low", scl_hold, 1);
      wr_tx(8'hA5);
      chk("R3 write clears stretch", stretch, 0);
      chk("R3 tx_empty", tx_empty, 0);
      chk("R3 tx_irq", tx_irq, 0);
      rise(1'b1);
      fall();
      chk("R4 count", cnt, 1);
      chk("R4 tx_empty", tx_empty, 1);
      chk("R4 tx_irq", tx_irq, 1);
      chk("R7 ack-time flag after address", flags[0], 1);
      chk("R4 no count flag yet", flags[1], 0);
      pulse_clr(5'b00001);
      chk("R12 flag cleared", flags[0], 0);
      send_byte(8'hA5);
      chk("R5 released in ack slot", sda_out, 1);
      chk("R6 stretch after 8th fall", stretch, 1);
      wr_tx(8'h3C);
      chk("R6 write releases", stretch, 0);
      rise(1'b0);
      chk("R7 ack_stat", ack_stat, 0);
      chk("R7 ack-time flag", flags[0], 1);
      chk("R7 no hold when disabled", stretch, 0);
      fall();
      chk("R4 count zero", cnt, 0);
      chk("R4 count flag", flags[1], 1);
      send_byte(8'h3C);
      chk("R6 no stretch at zero count", stretch, 0);
      rise(1'b1);
      chk("R7 nack captured", ack_stat, 1);
      fall();
      chk("R9 nack flag", flags[2], 1);
      chk("R9 active cleared", active, 0);
      chk("R9 err_irq", err_irq, 1);
      chk("R5 released after nack", sda_out, 1);
      stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
      chk("R10 stop flag", flags[3], 1);
      pulse_clr(5'b00100);
      chk("R9 err_irq clears", err_irq, 0);
   endtask

   task automatic t_ack_hold();
      do_reset();
      ackt_hold_en = 1'b1;
      wr_tx(8'h81);
      ld_cnt(1);
      match();
      chk("R2 no stretch when full", stretch, 0);
      rise(1'b1);
      fall();
      chk("R7 hold after address ack", stretch, 1);
      chk("R7 irq", irq, 1);
      chk("R11 hold", scl_hold, 1);
      wr_tx(8'h00);
      chk("R3 write keeps ack hold", stretch, 1);
      stretch_clr = 1'b1; @(negedge clk); stretch_clr = 1'b0;
      chk("R3 clear releases", stretch, 0);
      send_byte(8'h81);
      chk("R6 buffer full no stretch", stretch, 0);
      rise(1'b1);
      chk("R7 hold on controller ack slot", stretch, 1);
      restart_det = 1'b1; @(negedge clk); restart_det = 1'b0;
      chk("R10 restart flag", flags[4], 1);
      chk("R10 inactive", active, 0);
      chk("R10 sda released", sda_out, 1);
   endtask

   task automatic t_csd();
      do_reset();
      stretch_dis = 1'b1;
      ld_cnt(1);
      match();
      chk("R11 stretch bit still set", stretch, 1);
      chk("R11 no hold when disabled", scl_hold, 0);
      stretch_dis = 1'b0; #1;
      chk("R11 hold when enabled", scl_hold, 1);
      scl_in = 1'b1; #1;
      chk("R11 no hold while high", scl_hold, 0);
      @(negedge clk);
   endtask

   task automatic t_overflow();
      do_reset();
      rx_ovf = 1'b1;
      ld_cnt(1);
      match();
      chk("R8 nack flag", flags[2], 1);
      chk("R8 inactive", active, 0);
      chk("R8 sda released", sda_out, 1);
      chk("R8 stretch unchanged", stretch, 0);
   endtask

   task automatic t_zero_count();
      do_reset();
      match();
      chk("R2 zero count no stretch", stretch, 0);
      chk("R2 ack", sda_out, 0);
      rise(1'b1);
      fall();
      chk("R4 no load tx_empty", tx_empty, 1);
      chk("R4 count stays", cnt, 0);
      chk("R4 no count flag", flags[1], 0);
      chk("R4 released", sda_out, 1);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_stream();
      t_ack_hold();
      t_csd();
      t_overflow();
      t_zero_count();
      finish_run();
   end
endmodule